// File: doc/BRIEF.md
# Privileged Hardware Register Read Gate

This block serves an instruction that lets user code read a small set of hardware registers. A request carries a 5-bit selector and a kernel-mode flag. The block returns the selected value, or it asks the pipeline to raise a reserved-instruction trap. The registers it can return are:

- the processor number, taken from the low bits of the exception-base register;
- the instruction-cache synchronisation step size;
- a free-running cycle counter;
- the resolution of that counter.

Each of the four registers has its own access gate. Kernel mode opens every gate. Otherwise a per-register bit in an enable mask decides. The enable mask is held inside the block and is written through a simple write strobe. The cycle counter and its prescaler also live inside the block, so the block is complete on its own.

Top module: `hwreg_read_gate`

## Requirements
- R1: After reset, rd_valid is 0, ri_trap is 0 and rd_data is 0.
- R2: Selector 0, when granted, returns bits [9:0] of ebase, zero-extended. The upper bits of ebase do not affect the result.
- R3: Selector 1, when granted, returns step_size unchanged.
- R4: Selector 2, when granted, returns the cycle counter as it stood on the request edge. The counter is 0 after reset and rises by one every RES clocks, where RES defaults to 2.
- R5: Selector 3, when granted, returns the constant RES.
- R6: A read of selector n (n = 0 to 3) is granted when kernel is 1 or when bit n of the enable mask is 1. An enable write (en_we with en_wdata) applies to requests from the following cycle onward.
- R7: A denied read sets ri_trap together with rd_valid, and leaves rd_data at its previous value.
- R8: Selectors 4 to 31, including 29, always trap, whatever the value of kernel or of the mask.
- R9: rd_valid is 1 in exactly the cycle after each cycle in which req is 1, and 0 otherwise. ri_trap is never 1 without rd_valid.
- R10: The enable mask resets to all zeros, so a user-mode read made before any enable write traps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Read request strobe, one cycle per read |
| sel | input | 5 | Register selector |
| kernel | input | 1 | Core is in kernel mode or has coprocessor-0 access |
| ebase | input | 32 | Exception-base register; the low 10 bits hold the processor number |
| step_size | input | 32 | Instruction-cache synchronisation step |
| en_we | input | 1 | Write strobe for the enable mask |
| en_wdata | input | 4 | New enable mask, bit n opens selector n |
| rd_valid | output | 1 | Result strobe, one cycle after req |
| rd_data | output | 32 | Last granted value |
| ri_trap | output | 1 | Reserved-instruction trap request |

## Verification
The assertions check the following on every cycle:
- the one-cycle link between req and rd_valid;
- that ri_trap only appears together with rd_valid;
- that rd_data holds its value on a trap;
- that out-of-range selectors always trap;
- that kernel mode is never denied a read;
- that the counter only moves forward, one step at a time.

Only the bench scenarios can show the values themselves:
- the masking of ebase;
- the counter value captured on a given edge;
- the per-bit user gating after mask writes, including a write made in the same cycle as a request;
- the all-zero mask left by reset.

// File: rtl/hwreg_read_gate.sv
module hwreg_read_gate #(
  parameter int DATA_W = 32,
  parameter int CPU_W  = 10,
  parameter int SEL_W  = 5,
  parameter int RES    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [SEL_W-1:0]  sel,
  input  logic              kernel,
  input  logic [DATA_W-1:0] ebase,
  input  logic [DATA_W-1:0] step_size,
  input  logic              en_we,
  input  logic [3:0]        en_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              ri_trap
);
  localparam int NUM_HW = 4;
  localparam int PRE_W  = (RES > 1) ? $clog2(RES) : 1;

  logic [NUM_HW-1:0] en_mask;
  logic [PRE_W-1:0]  pre;
  logic [DATA_W-1:0] cyc_cnt;
  logic [DATA_W-1:0] src;

  wire unused_ebase_hi = ^ebase[DATA_W-1:CPU_W];
  wire in_range = (sel < SEL_W'(NUM_HW));
  wire granted  = in_range && (kernel || en_mask[sel[1:0]]);
  wire tick     = (pre == PRE_W'(RES - 1));

  always_comb begin
    case (sel[1:0])
      2'd0:    src = {{(DATA_W-CPU_W){1'b0}}, ebase[CPU_W-1:0]};
      2'd1:    src = step_size;
      2'd2:    src = cyc_cnt;
      default: src = DATA_W'(RES);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre     <= '0;
      cyc_cnt <= '0;
    end else if (tick) begin
      pre     <= '0;
      cyc_cnt <= cyc_cnt + 1'b1;
    end else begin
      pre     <= pre + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_mask <= '0;
    else if (en_we) en_mask <= en_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      ri_trap  <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= req;
      ri_trap  <= req && !granted;
      if (req && granted) rd_data <= src;
    end
  end

  p_trap_with_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ri_trap |-> rd_valid);
  p_valid_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> rd_valid);
  p_no_spurious_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !rd_valid);
  p_trap_keeps_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ri_trap |-> $stable(rd_data));
  p_bad_sel_traps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && sel >= SEL_W'(NUM_HW)) |=> ri_trap);
  p_kernel_granted_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && kernel && sel < SEL_W'(NUM_HW)) |=> !ri_trap);
  p_counter_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_cnt != $past(cyc_cnt)) |-> (cyc_cnt == $past(cyc_cnt) + 1'b1));
endmodule

// File: tb/hwreg_read_gate_test.sv
module hwreg_read_gate_test;
  localparam int RES = 2;
  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, kernel = 1'b0, en_we = 1'b0;
  logic [4:0] sel = '0;
  logic [31:0] ebase = 32'hABCD_E3C5, step_size = 32'd64;
  logic [3:0] en_wdata = '0;
  logic rd_valid, ri_trap;
  logic [31:0] rd_data;
  int checks = 0, errors = 0;
  bit done = 0;

  hwreg_read_gate #(.RES(RES)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .sel(sel), .kernel(kernel),
    .ebase(ebase), .step_size(step_size), .en_we(en_we), .en_wdata(en_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ri_trap(ri_trap));

  always #4 clk = ~clk;

  // behavioural reference model
  int m_pre, m_mask;
  longint m_cnt;
  logic m_valid, m_trap;
  logic [31:0] m_data;
  string m_tag = "R1";
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_mask = 0;
      m_valid = 0; m_trap = 0; m_data = 0; m_tag = "R1";
    end else begin
      m_valid = req;
      m_trap = 0;
      if (req) begin
        if (sel > 3) begin
          m_trap = 1; m_tag = "R8";
        end else if (!(kernel || m_mask[sel])) begin
          m_trap = 1; m_tag = "R7";
        end else begin
          case (sel)
            0: begin m_data = {22'd0, ebase[9:0]}; m_tag = "R2"; end
            1: begin m_data = step_size; m_tag = "R3"; end
            2: begin m_data = 32'(m_cnt); m_tag = "R4"; end
            default: begin m_data = 32'(RES); m_tag = "R5"; end
          endcase
        end
      end else m_tag = "R9";
      if (en_we) m_mask = int'(en_wdata);
      if (m_pre == RES - 1) begin m_pre = 0; m_cnt++; end
      else m_pre++;
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    check({m_tag, "/R9 valid"}, 32'(rd_valid), 32'(m_valid));
    check({m_tag, " trap"}, 32'(ri_trap), 32'(m_trap));
    check({m_tag, " data"}, rd_data, m_data);
  end

  task automatic rd(input logic [4:0] s, input logic k);
    @(negedge clk); req = 1; sel = s; kernel = k;
    @(negedge clk); req = 0; kernel = 0;
  endtask

  task automatic wr_mask(input logic [3:0] m);
    @(negedge clk); en_we = 1; en_wdata = m;
    @(negedge clk); en_we = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", 32'(rd_valid), 0);
    check("R1 data", rd_data, 0);
    rst_n = 1;
    rd(5'd0, 0); check("R10 user read traps after reset", 32'(ri_trap), 1);
    rd(5'd2, 0); check("R10", 32'(ri_trap), 1);
    rd(5'd0, 1); check("R2 cpu number", rd_data, 32'h3C5);
    rd(5'd1, 1); check("R3 step", rd_data, 32'd64);
    rd(5'd3, 1); check("R5 res", rd_data, 32'(RES));
    rd(5'd2, 1);
    rd(5'd2, 1);
    repeat (7) @(negedge clk);
    rd(5'd2, 1);
    rd(5'd3, 0); check("R7 data kept", rd_data, m_data);
    wr_mask(4'b0101);
    rd(5'd0, 0); check("R6 bit0 grants", 32'(ri_trap), 0);
    rd(5'd1, 0); check("R6 bit1 denies", 32'(ri_trap), 1);
    rd(5'd2, 0); check("R6 bit2 grants", 32'(ri_trap), 0);
    rd(5'd3, 0); check("R6 bit3 denies", 32'(ri_trap), 1);
    // mask write in the same cycle as a request: old mask applies
    @(negedge clk); req = 1; sel = 5'd3; en_we = 1; en_wdata = 4'b1000;
    @(negedge clk); req = 1; en_we = 0;
    check("R6 same-cycle write uses old mask", 32'(ri_trap), 1);
    @(negedge clk); req = 0;
    check("R6 write applies next cycle", 32'(ri_trap), 0);
    rd(5'd29, 1); check("R8 sel29 traps", 32'(ri_trap), 1);
    rd(5'd4, 1);  check("R8 sel4 traps", 32'(ri_trap), 1);
    wr_mask(4'b1111);
    rd(5'd31, 0); check("R8 sel31 traps", 32'(ri_trap), 1);
    ebase = 32'hFFFF_FC00; step_size = 32'd32;
    rd(5'd0, 0); check("R2 upper ebase ignored", rd_data, 32'h0);
    rd(5'd1, 0); check("R3 new step", rd_data, 32'd32);
    // back-to-back requests
    @(negedge clk); req = 1; sel = 5'd2; kernel = 1;
    @(negedge clk); sel = 5'd3;
    @(negedge clk); req = 0; kernel = 0;
    check("R9 back-to-back valid", 32'(rd_valid), 1);
    repeat (3) @(negedge clk);
    check("R9 idle", 32'(rd_valid), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule